// File: doc/BRIEF.md
# Cycling Vernier Time-to-Digital Converter

This block measures the interval between a START pulse and a later STOP pulse by the Vernier method, in discrete time: one clock cycle is one base tick. An accepted START launches a front into a slow recirculating line, where each stage takes `SLOW_TICKS` cycles. STOP launches a second front into a fast recirculating line, where each stage takes `FAST_TICKS` cycles. The fast front gains `SLOW_TICKS - FAST_TICKS` ticks per stage. The result is the index of the first stage that the fast front enters no later than the slow front. With the defaults (7 and 6) this gain is one tick, so the code equals the START-to-STOP distance in cycles.

Each line is a short ring of `RING_STAGES` positions plus a lap counter, not a 128-stage chain. The stage index is formed from lap and position. Conversion time is not fixed: a result arrives 7·D cycles after START for a distance of D ticks. A busy flag covers the whole conversion. A one-cycle valid strobe marks each new code, and an overflow flag marks a saturated result.

Top module: `vernier_tdc`

## Requirements
- R1: After synchronous active-high reset, busy_o, valid_o and ovf_o are 0 and code_o is 0.
- R2: With default parameters, a STOP sampled D clock edges after START (0 ≤ D ≤ 126) gives code_o = D (unsigned binary) with ovf_o = 0.
- R3: valid_o is a one-cycle pulse. If START is sampled at edge E, valid_o is high in the cycle after edge E + 7·D.
- R4: busy_o is high from the cycle after the accepted START through the valid cycle, and low in the cycle after valid_o.
- R5: A START pulse while busy_o is high, including in the valid cycle, is ignored and leaves the result unchanged.
- R6: A STOP pulse with no START pending does not start a conversion. A second STOP during a conversion does not change its result.
- R7: If STOP does not arrive within 126 edges after START, the result is code_o = 127 with ovf_o = 1, and valid_o is high in the cycle after edge E + 127.
- R8: code_o and ovf_o hold their last result until the next valid_o. A normal result clears ovf_o.
- R9: Both rings wrap their position modulo RING_STAGES and count laps, so codes spanning several laps come out exact.
- R10: START and STOP sampled on the same edge give code_o = 0, and valid_o is high in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is one base tick |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START event pulse |
| stop_i | input | 1 | STOP event pulse |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| code_o | output | CODE_W | Measured interval in LSB units |
| ovf_o | output | 1 | Result saturated at the top code |

## Verification
Every result is due at a cycle fixed by its own inputs. That is 7·D edges after the START edge for a normal result, the START edge itself for a zero distance, and 127 edges after START for overflow. Busy rises on the first cycle after START and falls on the cycle after the strobe. The driver stamps each expected result with its due cycle before pushing it to the scoreboard. The monitor samples on the falling clock edge, pops one entry per strobe, and compares the cycle number, code, overflow flag and busy level. A strobe in any other cycle, or one with nothing queued, is reported as a failure.

// File: rtl/vtdc_pkg.sv
package vtdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RACE,
        ST_DONE
    } tdc_state_e;
endpackage

// File: rtl/vtdc_ring.sv
module vtdc_ring #(
    parameter int STAGE_TICKS = 7,
    parameter int RING_STAGES = 8,
    parameter int POS_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic             halt_i,
    output logic             enter_o,
    output logic [POS_W-1:0] pos_nx_o
);
    localparam int TICK_W = $clog2(STAGE_TICKS + 1);
    localparam int IDX_W  = $clog2(RING_STAGES);
    localparam int LAP_W  = POS_W - IDX_W;

    typedef struct packed {
        logic              running;
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
        logic [LAP_W-1:0]  lap;
    } ring_t;

    ring_t r_d, r_q;
    logic  enter;

    always_comb begin
        r_d   = r_q;
        enter = 1'b0;
        if (halt_i) begin
            r_d.running = 1'b0;
        end else if (launch_i) begin
            r_d.running = 1'b1;
            r_d.tick    = TICK_W'(1);
            r_d.idx     = '0;
            r_d.lap     = '0;
            enter       = 1'b1;
        end else if (r_q.running) begin
            if (r_q.tick == TICK_W'(STAGE_TICKS)) begin
                enter    = 1'b1;
                r_d.tick = TICK_W'(1);
                if (r_q.idx == IDX_W'(RING_STAGES - 1)) begin
                    r_d.idx = '0;
                    r_d.lap = r_q.lap + 1'b1;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end else begin
                r_d.tick = r_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign enter_o  = enter;
    assign pos_nx_o = {r_d.lap, r_d.idx};

    AST_RING_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        r_q.running |-> (r_q.tick >= TICK_W'(1) && r_q.tick <= TICK_W'(STAGE_TICKS))); // R3
    AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
        (enter && !launch_i && !halt_i && r_q.idx == IDX_W'(RING_STAGES - 1)) |=> (r_q.idx == '0)); // R9
    AST_RING_LAP: assert property (@(posedge clk) disable iff (rst)
        (enter && !launch_i && !halt_i && r_q.idx == IDX_W'(RING_STAGES - 1)) |=> (r_q.lap == $past(r_q.lap) + 1'b1)); // R9
endmodule

// File: rtl/vtdc_ctrl.sv
module vtdc_ctrl
    import vtdc_pkg::*;
#(
    parameter int CODE_W     = 7,
    parameter int STEP_TICKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              slow_go_o,
    output logic              fast_go_o,
    output logic              halt_o,
    input  logic              slow_enter_i,
    input  logic              fast_enter_i,
    input  logic [CODE_W-1:0] slow_pos_i,
    input  logic [CODE_W-1:0] fast_pos_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o
);
    localparam int CODE_MAX  = (1 << CODE_W) - 1;
    localparam int OVF_TICKS = CODE_MAX * STEP_TICKS;
    localparam int WAIT_W    = $clog2(OVF_TICKS + 1);
    localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(OVF_TICKS);

    typedef struct packed {
        tdc_state_e        st;
        logic [WAIT_W-1:0] wait_cnt;
        logic [CODE_W-1:0] code;
        logic              ovf;
        logic              valid;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  slow_go, fast_go, caught;

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        slow_go   = (c_q.st == ST_IDLE) && start_i;
        fast_go   = (slow_go && stop_i) ||
                    (c_q.st == ST_WAIT && stop_i && c_q.wait_cnt != WAIT_LIM);
        caught    = fast_enter_i &&
                    ((fast_pos_i > slow_pos_i) || (fast_pos_i == slow_pos_i && slow_enter_i));
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st       = ST_WAIT;
                    c_d.wait_cnt = WAIT_W'(1);
                end
            end
            ST_WAIT: begin
                if (c_q.wait_cnt == WAIT_LIM) begin
                    c_d.st    = ST_DONE;
                    c_d.code  = CODE_W'(CODE_MAX);
                    c_d.ovf   = 1'b1;
                    c_d.valid = 1'b1;
                end else begin
                    c_d.wait_cnt = c_q.wait_cnt + 1'b1;
                    if (stop_i) c_d.st = ST_RACE;
                end
            end
            ST_RACE: begin
                if (!caught && fast_enter_i && fast_pos_i == CODE_W'(CODE_MAX)) begin
                    c_d.st    = ST_DONE;
                    c_d.code  = CODE_W'(CODE_MAX);
                    c_d.ovf   = 1'b1;
                    c_d.valid = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (caught && c_q.st != ST_DONE) begin
            c_d.st    = ST_DONE;
            c_d.code  = fast_pos_i;
            c_d.ovf   = 1'b0;
            c_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{st: ST_IDLE, wait_cnt: '0, code: '0, ovf: 1'b0, valid: 1'b0};
        else     c_q <= c_d;
    end

    assign slow_go_o = slow_go;
    assign fast_go_o = fast_go;
    assign halt_o    = (c_q.st == ST_DONE);
    assign busy_o    = (c_q.st != ST_IDLE);
    assign valid_o   = c_q.valid;
    assign code_o    = c_q.code;
    assign ovf_o     = c_q.ovf;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R3
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !busy_o); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !valid_o) |=> busy_o); // R4
    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (code_o == CODE_W'(CODE_MAX))); // R7
    AST_IDLE_STOP_INERT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> !busy_o); // R6
endmodule

// File: rtl/vernier_tdc.sv
module vernier_tdc #(
    parameter int CODE_W      = 7,
    parameter int SLOW_TICKS  = 7,
    parameter int FAST_TICKS  = 6,
    parameter int RING_STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o
);
    localparam int NUM_LINES  = 2;
    localparam int STEP_TICKS = SLOW_TICKS - FAST_TICKS;

    logic [NUM_LINES-1:0] go;
    logic [NUM_LINES-1:0] enter;
    logic [CODE_W-1:0]    pos_nx [NUM_LINES];
    logic                 halt;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int LINE_TICKS = (g == 0) ? SLOW_TICKS : FAST_TICKS;
        vtdc_ring #(
            .STAGE_TICKS(LINE_TICKS),
            .RING_STAGES(RING_STAGES),
            .POS_W      (CODE_W)
        ) u_ring (
            .clk     (clk),
            .rst     (rst),
            .launch_i(go[g]),
            .halt_i  (halt),
            .enter_o (enter[g]),
            .pos_nx_o(pos_nx[g])
        );
    end

    vtdc_ctrl #(
        .CODE_W    (CODE_W),
        .STEP_TICKS(STEP_TICKS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .slow_go_o   (go[0]),
        .fast_go_o   (go[1]),
        .halt_o      (halt),
        .slow_enter_i(enter[0]),
        .fast_enter_i(enter[1]),
        .slow_pos_i  (pos_nx[0]),
        .fast_pos_i  (pos_nx[1]),
        .busy_o      (busy_o),
        .valid_o     (valid_o),
        .code_o      (code_o),
        .ovf_o       (ovf_o)
    );
endmodule

// File: tb/vernier_tdc_tb_top.sv
module vernier_tdc_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       busy_o, valid_o, ovf_o;
    logic [6:0] code_o;

    always #10 clk = ~clk;

    vernier_tdc dut_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .stop_i (stop_i),
        .busy_o (busy_o),
        .valid_o(valid_o),
        .code_o (code_o),
        .ovf_o  (ovf_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        int cyc;
        int code;
        bit ovf;
    } exp_t;
    exp_t sb[$];
    bit   prev_valid = 1'b0;

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (prev_valid) chk(!busy_o, "R4", "busy after strobe", int'(busy_o), 0);
            if (valid_o) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3", "unexpected strobe", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(cyc == e.cyc, "R3", "strobe cycle", cyc, e.cyc);
                    chk(int'(code_o) == e.code, "R2", "code", int'(code_o), e.code);
                    chk(ovf_o == e.ovf, "R7", "overflow flag", int'(ovf_o), int'(e.ovf));
                    chk(busy_o, "R4", "busy at strobe", int'(busy_o), 1);
                end
            end
            prev_valid = valid_o;
        end
    end

    // driver: d < 0 means no STOP; xs / xp are extra START / STOP offsets (-1 none)
    task automatic conv(input int d, input int xs, input int xp, input string tag);
        int  e_edge;
        int  len;
        int  expc;
        bit  eo;
        eo   = (d < 0) || (d >= 127);
        expc = eo ? 127 : d;
        len  = eo ? 127 : 7 * d;
        e_edge = 0;
        for (int j = 0; j <= len + 1; j++) begin
            @(negedge clk);
            if (j == 0) begin
                e_edge = cyc + 1;
                sb.push_back('{e_edge + len, expc, eo});
            end
            if (j == 1) chk(busy_o, "R4", "busy after START", int'(busy_o), 1);
            start_i = (j == 0) || (j == xs);
            stop_i  = (j == d) || (j == xp);
        end
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, tag, "result delivered", sb.size(), 0);
        chk(int'(code_o) == expc, "R8", "code held", int'(code_o), expc);
        chk(ovf_o == eo, "R8", "overflow held", int'(ovf_o), int'(eo));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !valid_o && !ovf_o && code_o == 7'd0, "R1", "reset state",
            int'({busy_o, valid_o, ovf_o}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        conv(0, -1, -1, "R10");
        conv(1, -1, -1, "R2");
        conv(5, -1, -1, "R2");
        conv(6, -1, -1, "R2");
        conv(7, -1, -1, "R2");
        conv(8, -1, -1, "R9");
        conv(13, -1, -1, "R9");
        conv(20, -1, -1, "R9");
        conv(50, -1, -1, "R9");
        conv(126, -1, -1, "R2");
        conv(127, -1, -1, "R7");
        conv(-1, -1, -1, "R7");
        conv(140, -1, -1, "R7");
        conv(3, -1, -1, "R8");
        conv(10, 3, -1, "R5");
        conv(10, 71, -1, "R5");
        conv(9, -1, 12, "R6");

        // R6: STOP alone while idle
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy_o, "R6", "busy after lone STOP", int'(busy_o), 0);
        chk(int'(code_o) == 9, "R6", "code after lone STOP", int'(code_o), 9);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule